// File: doc/BRIEF.md
# Multi-Locality Access Arbiter

This block decides which of five software localities (numbered 0 to 4) owns a shared security-module register interface at any moment. Each locality reaches its own byte-wide access register through a byte-wide register port. The locality number forms the upper address bits and selects a 4 KiB window. The access register sits at the base of that window.

A locality asks for the interface by writing a request bit. It then polls its own register to learn whether it has become the owner. The same register shows whether some other locality is queued behind it. The owner gives the interface up by writing the ownership bit. A queued requester then takes over on that same edge, with no further write. Downstream logic follows the current owner through a registered valid/number pair.

Top module: `lar_arbiter`

## Requirements
- R1: After reset no locality owns the interface (`act_valid`=0), and reading the access register of any locality 0..4 returns 0x80, with bit 7 set as the valid flag.
- R2: The locality number is address bits [15:12], and the access register is at offset 0x000 inside its window. Within a locality 0..4 window, any other offset reads 0x00 and ignores writes.
- R3: Bit 5 of a locality's access register reads 1 only when that locality is the current owner.
- R4: When no locality owns the interface, a write with bit 1 set (and bit 5 clear) grants that locality ownership on the clock edge that takes the write. `act_valid` and `act_loc` show the grant from that edge on.
- R5: Bit 2 of a locality's access register reads 1 when at least one other locality has a request waiting. That locality's own waiting request does not set it.
- R6: A request made while another locality owns the interface is held waiting. It is granted, with no further write, on the edge where the owner writes bit 5.
- R7: When several requests are waiting as the owner releases, the highest-numbered locality is granted.
- R8: A bit-5 write from a locality that is not the owner leaves the owner unchanged, and it withdraws that locality's own waiting request.
- R9: For locality numbers 5 to 15, writes are ignored and reads return 0xFF. Ownership never goes to such a number.
- R10: A write with both bit 5 and bit 1 set counts as a release only. The request part is ignored, so it never grants ownership.
- R11: `rd_data` changes only on the clock edge after a cycle with `rd_en` high, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Register address: locality in [15:12], offset in [11:0] |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe; `rd_data` is loaded on the next edge |
| rd_data | output | 8 | Registered read data |
| act_valid | output | 1 | A locality currently owns the interface |
| act_loc | output | 3 | Number of the owning locality, meaningful while `act_valid` is high |

## Verification
The bench queues requests from localities 1 and 3 behind owner 2 and releases twice. An arbiter that granted in arrival order, or lowest-number-first, would hand the interface to locality 1 before 3. It checks the waiting bit from both the owner's view and a waiter's view. A version that counted a locality's own request would show bit 2 to locality 1 when only locality 1 was queued, or miss the other waiter. It also covers non-owner releases, the cancelling of a waiting request, combined release-and-request writes, out-of-range windows and non-base offsets. A faulty decode there would steal ownership, leave a stale waiter that is granted later, or return the wrong fill byte.

// File: rtl/lar_pkg.sv
package lar_pkg;
  localparam int BYTE_W = 8;

  // Bit positions inside an access register
  localparam int BIT_VALID   = 7;
  localparam int BIT_OWNED   = 5;
  localparam int BIT_WAITING = 2;
  localparam int BIT_ASK     = 1;

  localparam logic [BYTE_W-1:0] FILL_NO_WINDOW = 8'hFF;
  localparam logic [BYTE_W-1:0] FILL_OTHER_OFS = 8'h00;

  typedef struct packed {
    logic hit;    // access register of a live locality
    logic live;   // locality number is in range
  } win_sel_t;
endpackage

// File: rtl/lar_decode.sv
module lar_decode #(
  parameter int NUM_LOC   = 5,
  parameter int ADDR_W    = 16,
  parameter int LOC_SHIFT = 12,
  parameter int LOC_W     = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [LOC_W-1:0]  loc,
  output lar_pkg::win_sel_t sel
);
  localparam int FIELD_W = ADDR_W - LOC_SHIFT;

  logic [FIELD_W-1:0]   field;
  logic [LOC_SHIFT-1:0] offset;

  assign field    = addr[ADDR_W-1:LOC_SHIFT];
  assign offset   = addr[LOC_SHIFT-1:0];
  assign loc      = field[LOC_W-1:0];
  assign sel.live = (field < FIELD_W'(NUM_LOC));
  assign sel.hit  = sel.live && (offset == '0);
endmodule

// File: rtl/lar_pick.sv
module lar_pick #(
  parameter int N     = 5,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // Highest set index wins: later iterations override earlier ones.
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/lar_core.sv
module lar_core #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_hit,
  input  logic [LOC_W-1:0]   wr_loc,
  input  logic               ask,
  input  logic               drop,
  output logic               own_valid,
  output logic [LOC_W-1:0]   own_loc,
  output logic [NUM_LOC-1:0] wait_q
);
  logic [NUM_LOC-1:0] req_vec;
  logic [NUM_LOC-1:0] win_mask;
  logic               owner_leaves;
  logic               free;
  logic               pick_any;
  logic [LOC_W-1:0]   pick_idx;

  assign owner_leaves = own_valid && wr_hit && drop && (wr_loc == own_loc);
  assign free         = !own_valid || owner_leaves;

  // Per-locality request state after this cycle's write
  for (genvar g = 0; g < NUM_LOC; g++) begin : g_req
    logic addressed;
    logic is_owner;
    assign addressed = wr_hit && (wr_loc == LOC_W'(g));
    assign is_owner  = own_valid && (own_loc == LOC_W'(g));
    assign req_vec[g] = (wait_q[g] && !(addressed && drop))
                      || (addressed && ask && !drop && !is_owner);
    assign win_mask[g] = (pick_idx == LOC_W'(g));
  end

  lar_pick #(.N(NUM_LOC), .IDX_W(LOC_W)) u_pick (
    .vec (req_vec),
    .any (pick_any),
    .idx (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      own_valid <= 1'b0;
      own_loc   <= '0;
      wait_q    <= '0;
    end else if (free && pick_any) begin
      own_valid <= 1'b1;
      own_loc   <= pick_idx;
      wait_q    <= req_vec & ~win_mask;
    end else begin
      if (free) own_valid <= 1'b0;
      wait_q <= req_vec;
    end
  end
endmodule

// File: rtl/lar_rdmux.sv
module lar_rdmux #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd_en,
  input  lar_pkg::win_sel_t           sel,
  input  logic [LOC_W-1:0]            loc,
  input  logic                        own_valid,
  input  logic [LOC_W-1:0]            own_loc,
  input  logic [NUM_LOC-1:0]          wait_q,
  output logic [lar_pkg::BYTE_W-1:0]  rd_data
);
  import lar_pkg::*;

  logic [NUM_LOC-1:0] others;
  logic [BYTE_W-1:0]  acc_val;
  logic [BYTE_W-1:0]  rd_next;

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_oth
    assign others[g] = wait_q[g] && (loc != LOC_W'(g));
  end

  always_comb begin
    acc_val              = '0;
    acc_val[BIT_VALID]   = 1'b1;
    acc_val[BIT_OWNED]   = own_valid && (own_loc == loc);
    acc_val[BIT_WAITING] = |others;
    if (!sel.live)     rd_next = FILL_NO_WINDOW;
    else if (!sel.hit) rd_next = FILL_OTHER_OFS;
    else               rd_next = acc_val;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/lar_arbiter.sv
module lar_arbiter #(
  parameter int NUM_LOC   = 5,
  parameter int ADDR_W    = 16,
  parameter int LOC_SHIFT = 12,
  parameter int LOC_W     = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       wr_en,
  input  logic [lar_pkg::BYTE_W-1:0] wr_data,
  input  logic                       rd_en,
  output logic [lar_pkg::BYTE_W-1:0] rd_data,
  output logic                       act_valid,
  output logic [LOC_W-1:0]           act_loc
);
  import lar_pkg::*;

  win_sel_t           sel;
  logic [LOC_W-1:0]   loc;
  logic [NUM_LOC-1:0] wait_q;
  logic               wr_unused_bits;

  assign wr_unused_bits = ^{wr_data[7:6], wr_data[4:2], wr_data[0]};

  lar_decode #(.NUM_LOC(NUM_LOC), .ADDR_W(ADDR_W), .LOC_SHIFT(LOC_SHIFT), .LOC_W(LOC_W)) u_dec (
    .addr (addr),
    .loc  (loc),
    .sel  (sel)
  );

  lar_core #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .wr_hit    (wr_en && sel.hit),
    .wr_loc    (loc),
    .ask       (wr_data[BIT_ASK]),
    .drop      (wr_data[BIT_OWNED]),
    .own_valid (act_valid),
    .own_loc   (act_loc),
    .wait_q    (wait_q)
  );

  lar_rdmux #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .sel       (sel),
    .loc       (loc),
    .own_valid (act_valid),
    .own_loc   (act_loc),
    .wait_q    (wait_q),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/lar_checker.sv
module lar_checker #(
  parameter int NUM_LOC   = 5,
  parameter int ADDR_W    = 16,
  parameter int LOC_SHIFT = 12,
  parameter int LOC_W     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic              rd_en,
  input logic [7:0]        rd_data,
  input logic              act_valid,
  input logic [LOC_W-1:0]  act_loc
);
  localparam int FIELD_W = ADDR_W - LOC_SHIFT;

  logic [FIELD_W-1:0] fld;
  logic               live;
  logic               base;
  logic               chk_unused_bits;

  assign fld  = addr[ADDR_W-1:LOC_SHIFT];
  assign live = fld < FIELD_W'(NUM_LOC);
  assign base = live && (addr[LOC_SHIFT-1:0] == '0);
  assign chk_unused_bits = ^{wr_data[7:6], wr_data[4:2], wr_data[0]};

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !act_valid); // R1

  AST_OWNER_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (act_valid && !(wr_en && base && fld == FIELD_W'(act_loc) && wr_data[5]))
    |=> (act_valid && act_loc == $past(act_loc))); // R6

  AST_IDLE_GRANT: assert property (@(posedge clk) disable iff (rst)
    (!act_valid && wr_en && base && wr_data[1] && !wr_data[5])
    |=> (act_valid && act_loc == LOC_W'($past(fld)))); // R4

  AST_NO_WINDOW_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !live) |=> (rd_data == 8'hFF)); // R9

  AST_OWNER_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    act_valid |-> (act_loc < LOC_W'(NUM_LOC))); // R9

  AST_VALID_FLAG: assert property (@(posedge clk) disable iff (rst)
    (rd_en && base) |=> rd_data[7]); // R1

  AST_COMBO_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    (!act_valid && wr_en && wr_data[5] && wr_data[1]) |=> !act_valid); // R10

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R11
endmodule

bind lar_arbiter lar_checker #(
  .NUM_LOC(NUM_LOC), .ADDR_W(ADDR_W), .LOC_SHIFT(LOC_SHIFT), .LOC_W(LOC_W)
) u_lar_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .act_valid(act_valid), .act_loc(act_loc)
);

// File: tb/lar_arbiter_bench.sv
`timescale 1ns/1ps
module lar_arbiter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic        act_valid;
  logic [2:0]  act_loc;

  int total = 0;
  int bad = 0;
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  lar_arbiter u_lar_arbiter (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .act_valid(act_valid), .act_loc(act_loc)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int loc, input int ofs, input logic [7:0] d);
    @(negedge clk);
    addr = {loc[3:0], ofs[11:0]}; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int loc, input int ofs, output logic [7:0] d);
    @(negedge clk);
    addr = {loc[3:0], ofs[11:0]}; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic check_owner(input string req, input bit v, input int l);
    check(req, int'(act_valid), int'(v));
    if (v) check(req, int'(act_loc), l);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check_owner("R1 idle after reset", 1'b0, 0);
    for (int l = 0; l < 5; l++) begin
      rd(l, 0, d);
      check("R1 reset access value", d, 8'h80);
    end
    rd(0, 12'h018, d);
    check("R2 non-base offset reads 0", d, 8'h00);
  endtask

  task automatic t_idle_grant();
    logic [7:0] d;
    wr(2, 0, 8'h02);
    check_owner("R4 idle request granted", 1'b1, 2);
    rd(2, 0, d);
    check("R3 owner sees bit5", d, 8'hA0);
    rd(0, 0, d);
    check("R3 non-owner bit5 clear", d, 8'h80);
  endtask

  task automatic t_queue_order();
    logic [7:0] d;
    wr(1, 0, 8'h02);
    rd(1, 0, d);
    check("R5 own waiting request not shown", d, 8'h80);
    wr(3, 0, 8'h02);
    check_owner("R6 waiter does not preempt", 1'b1, 2);
    rd(2, 0, d);
    check("R5 owner sees waiter", d, 8'hA4);
    rd(1, 0, d);
    check("R5 waiter sees other waiter", d, 8'h84);
    wr(2, 0, 8'h20);
    check_owner("R7 highest waiter wins", 1'b1, 3);
    rd(3, 0, d);
    check("R5 new owner sees locality 1 waiting", d, 8'hA4);
    wr(3, 0, 8'h20);
    check_owner("R6 waiter granted without rewrite", 1'b1, 1);
    rd(1, 0, d);
    check("R3 granted waiter sees bit5", d, 8'hA0);
  endtask

  task automatic t_foreign_release();
    logic [7:0] d;
    wr(0, 0, 8'h20);
    check_owner("R8 non-owner release ignored", 1'b1, 1);
    wr(4, 0, 8'h02);
    rd(1, 0, d);
    check("R5 locality 4 waiting", d, 8'hA4);
    wr(4, 0, 8'h20);
    rd(1, 0, d);
    check("R8 release withdraws waiting request", d, 8'hA0);
    wr(1, 0, 8'h20);
    check_owner("R8 no stale grant after withdrawal", 1'b0, 0);
    rd(1, 0, d);
    check("R3 released owner bit5 clear", d, 8'h80);
  endtask

  task automatic t_bad_window();
    logic [7:0] d;
    wr(5, 0, 8'h02);
    check_owner("R9 write to locality 5 ignored", 1'b0, 0);
    rd(7, 0, d);
    check("R9 read of locality 7", d, 8'hFF);
    wr(2, 12'h008, 8'h02);
    check_owner("R2 non-base write ignored", 1'b0, 0);
  endtask

  task automatic t_combo();
    wr(0, 0, 8'h22);
    check_owner("R10 combined write on idle", 1'b0, 0);
    wr(4, 0, 8'h02);
    check_owner("R4 locality 4 granted", 1'b1, 4);
    wr(4, 0, 8'h22);
    check_owner("R10 combined write by owner releases", 1'b0, 0);
  endtask

  task automatic t_hold();
    logic [7:0] d;
    rd(9, 0, d);
    check("R9 read of locality 9", d, 8'hFF);
    wr(3, 0, 8'h02);
    repeat (3) @(negedge clk);
    check("R11 rd_data held without rd_en", rd_data, 8'hFF);
    rd(3, 0, d);
    check("R11 new read loads", d, 8'hA0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_idle_grant();
    t_queue_order();
    t_foreign_release();
    t_bad_window();
    t_combo();
    t_hold();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule